// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status flags of a small processor core: carry, parity, auxiliary carry, zero, sign and overflow, plus the interrupt-enable bit. Instruction decode drives a three-bit command code to clear, set or invert the carry, to enable or mask interrupts, or to move the five low status flags to or from an eight-bit byte. A separate write port takes the full result flags of the arithmetic unit.

At most one change lands in any clock cycle. A non-idle command wins over a pending arithmetic write in the same cycle. The packed byte is held in a snapshot register that is refreshed only by the snapshot command. The flags and the snapshot can therefore be read as steady values between updates.

Top module: `status_flag_reg`

## Requirements
- R1: A synchronous active-high reset clears all seven flags, and `byte_out` reads 0x02 after the reset edge.
- R2: Command 1 clears CF, command 2 sets CF and command 3 inverts CF on the next edge. The other flags are unchanged.
- R3: Command 4 clears the interrupt-enable flag and command 5 sets it on the next edge. The other flags are unchanged.
- R4: Command 7 (snapshot) loads `byte_out` with CF in bit 0, PF in bit 2, AF in bit 4, ZF in bit 6 and SF in bit 7. Bit 1 is 1, and bits 3 and 5 are 0. The flags are unchanged.
- R5: Command 6 (load) writes CF, PF, AF, ZF and SF from `byte_in` bits 0, 2, 4, 6 and 7. OF and the interrupt-enable flag keep their values, and `byte_in` bits 1, 3 and 5 are ignored. For example, 0x1E gives SF=0, ZF=0, AF=1, PF=1 and CF=0.
- R6: With command 0 and `alu_we` high, the six status flags take `alu_flags` on the next edge. The bit order is {OF,SF,ZF,AF,PF,CF}, with CF in bit 0. The interrupt-enable flag is unchanged.
- R7: When the command is non-zero, `alu_we` and `alu_flags` have no effect in that cycle.
- R8: With command 0 and `alu_we` low, every flag holds its value.
- R9: `byte_out` changes only after a snapshot command or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Flag command code (0 is idle) |
| byte_in | input | 8 | Byte source for the load command |
| alu_we | input | 1 | Arithmetic flag write enable |
| alu_flags | input | 6 | Arithmetic flags {OF,SF,ZF,AF,PF,CF} |
| byte_out | output | 8 | Snapshot of the packed flag byte |
| cf | output | 1 | Carry flag |
| pf | output | 1 | Parity flag |
| af | output | 1 | Auxiliary carry flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Overflow flag |
| ie | output | 1 | Interrupt-enable flag |

## Verification
The bench builds the block with its default widths: an 8-bit byte, a 3-bit command code and a 6-bit arithmetic bus. These defaults make all eight command codes and every byte value reachable. Directed steps cover the carry and interrupt commands, the 0x1E load, a load with only the unused bits set, and the command-versus-arithmetic collision. A long pseudo-random run then mixes every command with arithmetic writes and mid-run resets.

// File: rtl/flag_pkg.sv
package flag_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 3;
    localparam int ALU_W  = 6;

    localparam int POS_CF  = 0;
    localparam int POS_ONE = 1;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;

    typedef struct packed {
        logic ie;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE  = 3'd0,
        CMD_CLR_C = 3'd1,
        CMD_SET_C = 3'd2,
        CMD_CPL_C = 3'd3,
        CMD_CLR_I = 3'd4,
        CMD_SET_I = 3'd5,
        CMD_LOAD  = 3'd6,
        CMD_SNAP  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        COP_CLR = 2'd0,
        COP_SET = 2'd1,
        COP_CPL = 2'd2
    } carry_op_e;

    typedef struct packed {
        logic      carry_en;
        carry_op_e carry_op;
        logic      int_en;
        logic      int_val;
        logic      load_en;
        logic      snap_en;
        logic      alu_en;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pack_flags(input flags_t f);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[POS_CF]  = f.cf;
        b[POS_ONE] = 1'b1;
        b[POS_PF]  = f.pf;
        b[POS_AF]  = f.af;
        b[POS_ZF]  = f.zf;
        b[POS_SF]  = f.sf;
        return b;
    endfunction

    function automatic flags_t merge_byte(input flags_t f, input logic [BYTE_W-1:0] b);
        flags_t r;
        r    = f;
        r.cf = b[POS_CF];
        r.pf = b[POS_PF];
        r.af = b[POS_AF];
        r.zf = b[POS_ZF];
        r.sf = b[POS_SF];
        return r;
    endfunction

    function automatic flags_t merge_alu(input flags_t f, input logic [ALU_W-1:0] a);
        flags_t r;
        r    = f;
        r.cf = a[0];
        r.pf = a[1];
        r.af = a[2];
        r.zf = a[3];
        r.sf = a[4];
        r.of = a[5];
        return r;
    endfunction

endpackage

// File: rtl/flag_cmd_decode.sv
module flag_cmd_decode
    import flag_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             alu_we,
    output ctrl_t            ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.carry_op = COP_CLR;
        unique case (cmd_e'(cmd))
            CMD_IDLE:  ctrl.alu_en = alu_we;
            CMD_CLR_C: begin ctrl.carry_en = 1'b1; ctrl.carry_op = COP_CLR; end
            CMD_SET_C: begin ctrl.carry_en = 1'b1; ctrl.carry_op = COP_SET; end
            CMD_CPL_C: begin ctrl.carry_en = 1'b1; ctrl.carry_op = COP_CPL; end
            CMD_CLR_I: begin ctrl.int_en = 1'b1; ctrl.int_val = 1'b0; end
            CMD_SET_I: begin ctrl.int_en = 1'b1; ctrl.int_val = 1'b1; end
            CMD_LOAD:  ctrl.load_en = 1'b1;
            CMD_SNAP:  ctrl.snap_en = 1'b1;
            default:   ctrl = '0;
        endcase
    end
endmodule

// File: rtl/flag_next_state.sv
module flag_next_state
    import flag_pkg::*;
(
    input  flags_t            cur,
    input  ctrl_t             ctrl,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ALU_W-1:0]  alu_flags,
    output flags_t            nxt
);
    always_comb begin
        nxt = cur;
        if (ctrl.carry_en) begin
            case (ctrl.carry_op)
                COP_CLR: nxt.cf = 1'b0;
                COP_SET: nxt.cf = 1'b1;
                COP_CPL: nxt.cf = ~cur.cf;
                default: nxt.cf = cur.cf;
            endcase
        end else if (ctrl.int_en) begin
            nxt.ie = ctrl.int_val;
        end else if (ctrl.load_en) begin
            nxt = merge_byte(cur, byte_in);
        end else if (ctrl.alu_en) begin
            nxt = merge_alu(cur, alu_flags);
        end
    end
endmodule

// File: rtl/flag_byte_snap.sv
module flag_byte_snap
    import flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snap_en,
    input  flags_t            cur,
    output logic [BYTE_W-1:0] byte_q
);
    always_ff @(posedge clk) begin
        if (rst)          byte_q <= pack_flags('0);
        else if (snap_en) byte_q <= pack_flags(cur);
    end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              alu_we,
    input  logic [ALU_W-1:0]  alu_flags,
    output logic [BYTE_W-1:0] byte_out,
    output logic              cf,
    output logic              pf,
    output logic              af,
    output logic              zf,
    output logic              sf,
    output logic              of,
    output logic              ie
);
    ctrl_t  ctrl;
    flags_t flags_q;
    flags_t flags_d;

    flag_cmd_decode u_dec (
        .cmd    (cmd),
        .alu_we (alu_we),
        .ctrl   (ctrl)
    );

    flag_next_state u_nxt (
        .cur       (flags_q),
        .ctrl      (ctrl),
        .byte_in   (byte_in),
        .alu_flags (alu_flags),
        .nxt       (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    flag_byte_snap u_snap (
        .clk     (clk),
        .rst     (rst),
        .snap_en (ctrl.snap_en),
        .cur     (flags_q),
        .byte_q  (byte_out)
    );

    assign cf = flags_q.cf;
    assign pf = flags_q.pf;
    assign af = flags_q.af;
    assign zf = flags_q.zf;
    assign sf = flags_q.sf;
    assign of = flags_q.of;
    assign ie = flags_q.ie;
endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk
    import flag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CMD_W-1:0]  cmd,
    input logic [BYTE_W-1:0] byte_in,
    input logic              alu_we,
    input logic [ALU_W-1:0]  alu_flags,
    input logic [BYTE_W-1:0] byte_out,
    input logic              cf,
    input logic              pf,
    input logic              af,
    input logic              zf,
    input logic              sf,
    input logic              of,
    input logic              ie
);
    logic [6:0] all_f;
    assign all_f = {ie, of, sf, zf, af, pf, cf};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (all_f == 7'd0 && byte_out == 8'h02));

    p_carry_clr_r2: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_CLR_C |=> !cf && $stable({ie, of, sf, zf, af, pf}));
    p_carry_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_SET_C |=> cf);
    p_carry_cpl_r2: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_CPL_C |=> cf != $past(cf));

    p_int_clr_r3: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_CLR_I |=> !ie && $stable({of, sf, zf, af, pf, cf}));
    p_int_set_r3: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_SET_I |=> ie);

    p_snap_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_SNAP |=> $stable(all_f) && byte_out[1] && !byte_out[3] && !byte_out[5]);

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_LOAD |=> cf == $past(byte_in[0]) && sf == $past(byte_in[7])
                            && $stable({ie, of}));

    p_alu_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE && alu_we) |=> {of, sf, zf, af, pf, cf} == $past(alu_flags) && $stable(ie));

    p_cmd_wins_r7: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_IDLE |=> $stable(of));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_IDLE && !alu_we) |=> $stable(all_f));

    p_byte_hold_r9: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_SNAP |=> $stable(byte_out));
endmodule

bind status_flag_reg status_flag_reg_chk u_chk (.*);

// File: tb/status_flag_reg_test.sv
module status_flag_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [7:0] byte_in = 8'd0;
    logic       alu_we = 1'b0;
    logic [5:0] alu_flags = 6'd0;
    logic [7:0] byte_out;
    logic       cf, pf, af, zf, sf, of, ie;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_cf, m_pf, m_af, m_zf, m_sf, m_of, m_ie;
    logic [7:0] m_byte;

    always #10 clk = ~clk;

    status_flag_reg uut (
        .clk(clk), .rst(rst), .cmd(cmd), .byte_in(byte_in), .alu_we(alu_we),
        .alu_flags(alu_flags), .byte_out(byte_out), .cf(cf), .pf(pf), .af(af),
        .zf(zf), .sf(sf), .of(of), .ie(ie)
    );

    task automatic model_update(input bit r, input int c, input logic [7:0] b,
                                input bit we, input logic [5:0] a);
        if (r) begin
            {m_cf, m_pf, m_af, m_zf, m_sf, m_of, m_ie} = '0;
            m_byte = 8'h02;
        end else begin
            case (c)
                0: if (we) {m_of, m_sf, m_zf, m_af, m_pf, m_cf} = a;
                1: m_cf = 0;
                2: m_cf = 1;
                3: m_cf = !m_cf;
                4: m_ie = 0;
                5: m_ie = 1;
                6: begin m_cf = b[0]; m_pf = b[2]; m_af = b[4]; m_zf = b[6]; m_sf = b[7]; end
                default: m_byte = {m_sf, m_zf, 1'b0, m_af, 1'b0, m_pf, 1'b1, m_cf};
            endcase
        end
    endtask

    task automatic compare(input string tag);
        logic [6:0] got, exp;
        got = {ie, of, sf, zf, af, pf, cf};
        exp = {m_ie, m_of, m_sf, m_zf, m_af, m_pf, m_cf};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s flags {ie,of,sf,zf,af,pf,cf} actual=%b expected=%b", tag, got, exp);
        end
        checks++;
        if (byte_out !== m_byte) begin
            fails++;
            $display("FAIL %s byte_out actual=%h expected=%h", tag, byte_out, m_byte);
        end
    endtask

    task automatic step(input string tag, input bit r, input int c, input logic [7:0] b,
                        input bit we, input logic [5:0] a);
        rst = r; cmd = c[2:0]; byte_in = b; alu_we = we; alu_flags = a;
        @(posedge clk);
        model_update(r, c, b, we, a);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        step("R1", 1, 0, 8'h00, 0, 6'h00);
        step("R1", 1, 5, 8'hFF, 1, 6'h3F);
        step("R2", 0, 2, 8'h00, 0, 6'h00);
        step("R2", 0, 3, 8'h00, 0, 6'h00);
        step("R2", 0, 3, 8'h00, 0, 6'h00);
        step("R2", 0, 1, 8'h00, 0, 6'h00);
        step("R3", 0, 5, 8'h00, 0, 6'h00);
        step("R3", 0, 4, 8'h00, 0, 6'h00);
        step("R3", 0, 5, 8'h00, 0, 6'h00);
        step("R6", 0, 0, 8'h00, 1, 6'h3F);
        step("R4", 0, 7, 8'h00, 0, 6'h00);
        step("R5", 0, 6, 8'h1E, 0, 6'h00);
        step("R4", 0, 7, 8'h00, 0, 6'h00);
        step("R5", 0, 6, 8'h2A, 0, 6'h00);
        step("R4", 0, 7, 8'h00, 0, 6'h00);
        step("R7", 0, 2, 8'h00, 1, 6'h15);
        step("R7", 0, 6, 8'hC1, 1, 6'h00);
        step("R8", 0, 0, 8'hFF, 0, 6'h2A);
        step("R9", 0, 0, 8'h55, 1, 6'h2A);
        step("R6", 0, 0, 8'h00, 1, 6'h15);
        step("R4", 0, 7, 8'h00, 1, 6'h00);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            int c;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = int'(lfsr[2:0]);
            step(c == 0 ? "R6" : (c == 7 ? "R4" : (c == 6 ? "R5" : "R7")),
                 (lfsr[15:11] == 5'd0), c, lfsr[10:3], lfsr[4], lfsr[9:4]);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule